// File: doc/BRIEF.md
# LFPS Burst Bit Classifier

This block watches a sampled, single-bit electrical-idle indicator and decides whether each low-frequency periodic signalling symbol carries a zero or a one. A symbol is a low run whose length must fall inside a tight window, followed at once by a high run. The length of the high run alone picks the bit value. The symbol is only decided when the indicator drops low again, and the block reports the result in that same cycle.

Two saturating counters measure the current low run and the current high run. When the line rises, the block arms itself if the low run that just ended fits the low window. When the line falls, an armed detector compares the high run against the zero window and the one window. It pulses the matching output, or a malformed pulse when the high run fits neither window. Every bound is a parameter, so the windows can be retuned.

Top module: `lfps_bit_classifier`

## Requirements
- R1: While rst_ni is low, and afterwards until a complete armed symbol has closed, zero_o, one_o and bad_o stay 0. A high run that is not preceded by a low run after reset produces no pulse.
- R2: A low run of LOW_MIN..LOW_MAX cycles (default 16..18, inclusive), then a high run of ZERO_MIN..ZERO_MAX cycles (default 102..104, inclusive), then a low sample, gives exactly one zero_o pulse. The pulse comes in the cycle of that first low sample.
- R3: The same low run followed by a high run of ONE_MIN..ONE_MAX cycles (default 180..184, inclusive), then a low sample, gives exactly one one_o pulse in the cycle of that first low sample.
- R4: A low run shorter than LOW_MIN or longer than LOW_MAX leaves the detector unarmed. The high run that follows gives no pulse on any output when the line falls.
- R5: After a valid low run, a high run whose length fits neither the zero window nor the one window gives exactly one bad_o pulse when the line falls.
- R6: The run counters saturate one above the largest bound. A high run of 359 cycles after a valid low run gives bad_o and not zero_o. A low run of 273 cycles leaves the detector unarmed.
- R7: The low sample that closes one symbol also counts as the first cycle of the next symbol's low run, so symbols can follow back to back.
- R8: zero_o, one_o and bad_o are mutually exclusive. Each lasts exactly one cycle, and a pulse occurs only in a cycle where idle_i is 0 and was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Sampled electrical-idle indicator, one sample per clock |
| zero_o | output | 1 | One-cycle pulse: zero symbol closed |
| one_o | output | 1 | One-cycle pulse: one symbol closed |
| bad_o | output | 1 | One-cycle pulse: armed symbol with an out-of-window high run |

## Verification
The assertions assume that idle_i is already synchronous to clk_i and free of X. They also assume it holds a defined level across the release of reset, because the edge-only property looks one sample into the past. The bench drives idle_i only on falling clock edges, holds it high for the whole reset, and sends only defined levels. Because of this, every past value the properties use is a real sample. Symbol lengths are chosen on and just outside each window bound, and at lengths that would alias into a window if a counter wrapped.

// File: rtl/lfps_pkg.sv
package lfps_pkg;
  function automatic int cnt_w(input int limit);
    return $clog2(limit + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lfps_run_cnt.sv
module lfps_run_cnt #(
  parameter int LIMIT  = 19,
  parameter bit ACTIVE = 1'b0,
  parameter int W      = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         line_i,
  input  logic         line_q_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LIM_C = W'(LIMIT);

  // holds its value while the line is inactive so the run length is visible at the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (line_i == ACTIVE) begin
      if (line_q_i != ACTIVE)  cnt_o <= W'(1);
      else if (cnt_o != LIM_C) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/lfps_win_chk.sv
module lfps_win_chk #(
  parameter int W  = 8,
  parameter int LO = 0,
  parameter int HI = 0
) (
  input  logic [W-1:0] cnt_i,
  output logic         hit_o
);
  localparam logic [W-1:0] LO_C = W'(LO);
  localparam logic [W-1:0] HI_C = W'(HI);

  assign hit_o = (cnt_i >= LO_C) && (cnt_i <= HI_C);
endmodule

// File: rtl/lfps_bit_classifier.sv
module lfps_bit_classifier
  import lfps_pkg::*;
#(
  parameter int LOW_MIN  = 16,
  parameter int LOW_MAX  = 18,
  parameter int ZERO_MIN = 102,
  parameter int ZERO_MAX = 104,
  parameter int ONE_MIN  = 180,
  parameter int ONE_MAX  = 184
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  output logic zero_o,
  output logic one_o,
  output logic bad_o
);
  localparam int LO_LIM = LOW_MAX + 1;
  localparam int HI_LIM = max2(ZERO_MAX, ONE_MAX) + 1;
  localparam int LO_W   = cnt_w(LO_LIM);
  localparam int HI_W   = cnt_w(HI_LIM);

  logic            line_q;
  logic            armed_q;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic            lo_hit, zero_hit, one_hit;
  logic            rise, fall, close;

  lfps_run_cnt #(.LIMIT(LO_LIM), .ACTIVE(1'b0), .W(LO_W)) u_lo_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(idle_i), .line_q_i(line_q), .cnt_o(lo_cnt)
  );

  lfps_run_cnt #(.LIMIT(HI_LIM), .ACTIVE(1'b1), .W(HI_W)) u_hi_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(idle_i), .line_q_i(line_q), .cnt_o(hi_cnt)
  );

  lfps_win_chk #(.W(LO_W), .LO(LOW_MIN), .HI(LOW_MAX)) u_lo_win (
    .cnt_i(lo_cnt), .hit_o(lo_hit)
  );

  lfps_win_chk #(.W(HI_W), .LO(ZERO_MIN), .HI(ZERO_MAX)) u_zero_win (
    .cnt_i(hi_cnt), .hit_o(zero_hit)
  );

  lfps_win_chk #(.W(HI_W), .LO(ONE_MIN), .HI(ONE_MAX)) u_one_win (
    .cnt_i(hi_cnt), .hit_o(one_hit)
  );

  assign rise  = idle_i & ~line_q;
  assign fall  = ~idle_i & line_q;
  assign close = fall & armed_q;

  // line_q resets high so a low right after reset starts a fresh low run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      line_q <= idle_i;
      if (rise)      armed_q <= lo_hit;
      else if (fall) armed_q <= 1'b0;
    end
  end

  assign zero_o = close & zero_hit;
  assign one_o  = close & one_hit;
  assign bad_o  = close & ~zero_hit & ~one_hit;
endmodule

// File: rtl/lfps_bit_classifier_chk.sv
module lfps_bit_classifier_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic idle_i,
  input logic zero_o,
  input logic one_o,
  input logic bad_o
);
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({zero_o, one_o, bad_o}));

  a_r2_zero_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |=> !zero_o);

  a_r3_one_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_o |=> !one_o);

  a_r5_bad_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> !bad_o);

  a_r8_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o || one_o || bad_o) |-> (!idle_i && $past(idle_i)));
endmodule

bind lfps_bit_classifier lfps_bit_classifier_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i),
  .zero_o(zero_o), .one_o(one_o), .bad_o(bad_o)
);

// File: tb/sim_lfps_bit_classifier.sv
`timescale 1ns/1ps
module sim_lfps_bit_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b1;
  logic zero, one, bad;

  int checks = 0;
  int fails = 0;
  int n_zero = 0, n_one = 0, n_bad = 0;

  // behavioural reference state
  int  m_lo = 0, m_hi = 0;
  bit  m_prev = 1'b1, m_armed = 1'b0;

  always #5 clk = ~clk;

  lfps_bit_classifier u0 (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle),
    .zero_o(zero), .one_o(one), .bad_o(bad)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit v);
    bit fall, ez, eo, eb;
    @(negedge clk);
    idle = v;
    #1;
    fall = m_prev && !v;
    ez = fall && m_armed && m_hi >= 102 && m_hi <= 104;
    eo = fall && m_armed && m_hi >= 180 && m_hi <= 184;
    eb = fall && m_armed && !ez && !eo;
    check("R8 zero_o per cycle", zero, ez);
    check("R8 one_o per cycle", one, eo);
    check("R8 bad_o per cycle", bad, eb);
    n_zero += zero; n_one += one; n_bad += bad;
    if (!v) begin
      m_lo = m_prev ? 1 : m_lo + 1;
      if (fall) m_armed = 1'b0;
    end else begin
      if (!m_prev) begin
        m_armed = (m_lo >= 16 && m_lo <= 18);
        m_hi = 1;
      end else m_hi = m_hi + 1;
    end
    m_prev = v;
  endtask

  task automatic run(input bit v, input int n);
    for (int i = 0; i < n; i++) step(v);
  endtask

  // isolated symbol: break any prior low run, then lo lows, hi highs, one closing low
  task automatic sym(input string req, input int lo, input int hi,
                     input int ez, input int eo, input int eb);
    int z0, o0, b0;
    run(1'b1, 3);
    z0 = n_zero; o0 = n_one; b0 = n_bad;
    run(1'b0, lo);
    run(1'b1, hi);
    step(1'b0);
    check({req, " zero count"}, n_zero - z0, ez);
    check({req, " one count"}, n_one - o0, eo);
    check({req, " bad count"}, n_bad - b0, eb);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 zero_o in reset", zero, 0);
    check("R1 one_o in reset", one, 0);
    check("R1 bad_o in reset", bad, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: high then fall with no prior low run -> nothing
    run(1'b1, 103);
    step(1'b0);
    check("R1 no pulse before a low run", n_zero + n_one + n_bad, 0);

    sym("R2 mid", 17, 103, 1, 0, 0);
    sym("R2 min", 16, 102, 1, 0, 0);
    sym("R2 max", 18, 104, 1, 0, 0);
    sym("R3 mid", 17, 182, 0, 1, 0);
    sym("R3 min", 16, 180, 0, 1, 0);
    sym("R3 max", 18, 184, 0, 1, 0);
    sym("R4 short low", 15, 103, 0, 0, 0);
    sym("R4 long low", 19, 182, 0, 0, 0);
    sym("R5 below zero", 17, 101, 0, 0, 1);
    sym("R5 above zero", 17, 105, 0, 0, 1);
    sym("R5 below one", 17, 179, 0, 0, 1);
    sym("R5 above one", 17, 185, 0, 0, 1);
    sym("R5 between", 17, 140, 0, 0, 1);
    sym("R6 long high", 17, 359, 0, 0, 1);
    sym("R6 long low", 273, 103, 0, 0, 0);

    // R7: closing low is the first low of the next symbol
    begin
      int z0, o0;
      run(1'b1, 3);
      z0 = n_zero; o0 = n_one;
      run(1'b0, 17);
      run(1'b1, 103);
      run(1'b0, 16);
      run(1'b1, 182);
      step(1'b0);
      check("R7 back-to-back zero", n_zero - z0, 1);
      check("R7 back-to-back one", n_one - o0, 1);
    end

    run(1'b0, 4);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule